// File: doc/BRIEF.md
# ATA Strobe Cycle Timing Generator

This block produces the active-low read and write strobes for a parallel ATA style bus. A 32-bit timing word controls it. Separate fields in that word set the strobe active time, the strobe inactive time and the first-cycle setup time. Data transfers (PIO or multiword DMA) use one set of fields. Task-file register accesses use another set.

A request is a single-clock start pulse. With it come an access-class flag, a direction bit and a word-cycle count. The block captures the request and the timing word when it accepts the start. It then runs the setup interval and the first active strobe phase. Each later cycle is an inactive phase followed by an active phase. A pulse marks the end of every cycle, and a further pulse marks the end of the burst. Each phase lasts the value of its field plus one clock.

Top module: `ata_strb_gen`

## Requirements
- R1: After reset, and at any time the block is idle, `busy_o` is 0, both strobes are 1 and both done pulses are 0.
- R2: For a data transfer (`is_cmd_i`=0), each active strobe phase lasts timing[8:4]+1 clocks. Between cycles, the inactive phase lasts timing[3:0]+1 clocks.
- R3: For a task-file access (`is_cmd_i`=1), each active phase lasts timing[17:13]+1 clocks. Between cycles, the inactive phase lasts timing[12:9]+1 clocks.
- R4: A start is accepted on a rising clock edge while idle. From the next clock on, both strobes stay high for the setup time before the first active phase. The setup time is timing[24:22]+1 clocks for data transfers and timing[27:25]+1 clocks for task-file accesses.
- R5: `write_i`=1 selects `wr_strobe_no` and `write_i`=0 selects `rd_strobe_no`. Only the selected strobe goes low. The two strobes are never low together.
- R6: `cycle_done_o` is high during the last clock of every active phase. `burst_done_o` is high only together with the last of these pulses. `busy_o` falls on the clock after `burst_done_o`.
- R7: A burst runs `count_i` cycles. A count of 0 runs exactly one cycle.
- R8: The timing word, the access class and the direction are captured when the start is accepted. Later changes to `timing_i`, `is_cmd_i` or `write_i` during a burst have no effect on it.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. This includes a start during the final clock of a burst.
- R10: `fifo_en_o` equals bit 31 of the last captured timing word. Its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse |
| is_cmd_i | input | 1 | 1 = task-file access, 0 = data transfer |
| write_i | input | 1 | 1 = write, 0 = read |
| count_i | input | CNT_W | Word cycles in the burst (0 is treated as 1) |
| timing_i | input | 32 | Timing word |
| rd_strobe_no | output | 1 | Read strobe, active low |
| wr_strobe_no | output | 1 | Write strobe, active low |
| cycle_done_o | output | 1 | Last clock of an active phase |
| burst_done_o | output | 1 | Last clock of the burst |
| busy_o | output | 1 | Burst in progress |
| fifo_en_o | output | 1 | Captured FIFO-enable bit |

## Verification
A wrong phase counter shows up as a strobe edge at the wrong clock. The bench compares every clock of a burst, so this is caught at the first misplaced edge. A wrong captured word or class flag changes the next phase length that gets loaded, and that shows within one phase. A wrong burst counter or state register shows up at the final `cycle_done_o`: either `burst_done_o` is missing, or an extra inactive/active pair appears before `busy_o` falls.

// File: rtl/ata_strb_pkg.sv
package ata_strb_pkg;
  localparam int TW   = 32;
  localparam int PH_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_ACT} st_e;

  typedef struct packed {
    logic [PH_W-1:0] act;
    logic [PH_W-1:0] inact;
    logic [PH_W-1:0] setup;
  } phase_len_t;

  // field positions of the timing word
  localparam int D_INACT_LO = 0,  D_INACT_HI = 3;
  localparam int D_ACT_LO   = 4,  D_ACT_HI   = 8;
  localparam int C_INACT_LO = 9,  C_INACT_HI = 12;
  localparam int C_ACT_LO   = 13, C_ACT_HI   = 17;
  localparam int D_SET_LO   = 22, D_SET_HI   = 24;
  localparam int C_SET_LO   = 25, C_SET_HI   = 27;
  localparam int FIFO_BIT   = 31;
endpackage

// File: rtl/ata_strb_timing_sel.sv
module ata_strb_timing_sel
  import ata_strb_pkg::*;
(
  input  logic [TW-1:0] word_i,
  input  logic          is_cmd_i,
  output phase_len_t    len_o
);
  phase_len_t dat_len, cmd_len;

  always_comb begin
    dat_len = '0;
    cmd_len = '0;
    dat_len.act   = PH_W'(word_i[D_ACT_HI:D_ACT_LO]);
    dat_len.inact = PH_W'(word_i[D_INACT_HI:D_INACT_LO]);
    dat_len.setup = PH_W'(word_i[D_SET_HI:D_SET_LO]);
    cmd_len.act   = PH_W'(word_i[C_ACT_HI:C_ACT_LO]);
    cmd_len.inact = PH_W'(word_i[C_INACT_HI:C_INACT_LO]);
    cmd_len.setup = PH_W'(word_i[C_SET_HI:C_SET_LO]);
    len_o = is_cmd_i ? cmd_len : dat_len;
  end
endmodule

// File: rtl/ata_strb_down_ctr.sv
module ata_strb_down_ctr #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] q_o,
  output logic         zero_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q <= '0;
    else if (load_i)              q <= val_i;
    else if (dec_i && q != '0)    q <= q - W'(1);
  end

  assign q_o    = q;
  assign zero_o = (q == '0);

  // R2
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && q == '0) |=> (q == '0));
endmodule

// File: rtl/ata_strb_seq.sv
module ata_strb_seq
  import ata_strb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  phase_len_t       new_len_i,
  input  phase_len_t       cur_len_i,
  output logic             accept_o,
  output logic             active_o,
  output logic             busy_o,
  output logic             cycle_done_o,
  output logic             burst_done_o
);
  st_e st_q, st_d;
  logic            ph_load, ph_zero;
  logic [PH_W-1:0] ph_val, ph_q;
  logic            bt_load, bt_dec, bt_zero;
  logic [CNT_W-1:0] bt_val, bt_q;
  logic            bt_last;

  ata_strb_down_ctr #(.W(PH_W)) u_ph_ctr (
    .clk_i, .rst_ni, .load_i(ph_load), .val_i(ph_val), .dec_i(1'b1),
    .q_o(ph_q), .zero_o(ph_zero));

  ata_strb_down_ctr #(.W(CNT_W)) u_bt_ctr (
    .clk_i, .rst_ni, .load_i(bt_load), .val_i(bt_val), .dec_i(bt_dec),
    .q_o(bt_q), .zero_o(bt_zero));

  assign bt_val  = (count_i == '0) ? CNT_W'(1) : count_i;
  assign bt_last = (bt_q == CNT_W'(1));

  always_comb begin
    st_d         = st_q;
    ph_load      = 1'b0;
    ph_val       = '0;
    bt_load      = 1'b0;
    bt_dec       = 1'b0;
    accept_o     = 1'b0;
    cycle_done_o = 1'b0;
    burst_done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        accept_o = 1'b1;
        ph_load  = 1'b1;
        ph_val   = new_len_i.setup;
        bt_load  = 1'b1;
        st_d     = ST_LEAD;
      end
      ST_LEAD: if (ph_zero) begin
        ph_load = 1'b1;
        ph_val  = cur_len_i.act;
        st_d    = ST_ACT;
      end
      ST_ACT: if (ph_zero) begin
        cycle_done_o = 1'b1;
        if (bt_last) begin
          burst_done_o = 1'b1;
          st_d         = ST_IDLE;
        end else begin
          ph_load = 1'b1;
          ph_val  = cur_len_i.inact;
          bt_dec  = 1'b1;
          st_d    = ST_LEAD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign active_o = (st_q == ST_ACT);
  assign busy_o   = (st_q != ST_IDLE);

  // R7
  burst_cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !bt_zero);

  // R6
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |=> !busy_o);

  // R6
  burst_on_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |-> (cycle_done_o && active_o));

  // R9
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !accept_o);
endmodule

// File: rtl/ata_strb_gen.sv
module ata_strb_gen
  import ata_strb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_cmd_i,
  input  logic             write_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [TW-1:0]    timing_i,
  output logic             rd_strobe_no,
  output logic             wr_strobe_no,
  output logic             cycle_done_o,
  output logic             burst_done_o,
  output logic             busy_o,
  output logic             fifo_en_o
);
  logic [TW-1:0] word_q;
  logic          cmd_q, dir_q;
  logic          accept, active;
  phase_len_t    new_len, cur_len;

  ata_strb_timing_sel u_sel_new (.word_i(timing_i), .is_cmd_i(is_cmd_i), .len_o(new_len));
  ata_strb_timing_sel u_sel_cur (.word_i(word_q),   .is_cmd_i(cmd_q),    .len_o(cur_len));

  ata_strb_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .count_i,
    .new_len_i(new_len), .cur_len_i(cur_len),
    .accept_o(accept), .active_o(active), .busy_o,
    .cycle_done_o, .burst_done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cmd_q  <= 1'b0;
      dir_q  <= 1'b0;
    end else if (accept) begin
      word_q <= timing_i;
      cmd_q  <= is_cmd_i;
      dir_q  <= write_i;
    end
  end

  assign rd_strobe_no = ~(active & ~dir_q);
  assign wr_strobe_no = ~(active &  dir_q);
  assign fifo_en_o    = word_q[FIFO_BIT];

  // R5
  no_dual_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_no || wr_strobe_no));

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_strobe_no && wr_strobe_no && !cycle_done_o));

  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(word_q) && $stable(cmd_q) && $stable(dir_q)));

  // R6
  done_in_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_o |-> !(rd_strobe_no && wr_strobe_no));
endmodule

// File: tb/ata_strb_gen_bench.sv
module ata_strb_gen_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_cmd = 1'b0, wr = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [31:0] tim = '0;
  logic rd_n, wr_n, cyc_done, bur_done, busy, fifo_en;
  int vectors = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ata_strb_gen #(.CNT_W(CNT_W)) u_ata_strb_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_cmd_i(is_cmd),
    .write_i(wr), .count_i(cnt), .timing_i(tim),
    .rd_strobe_no(rd_n), .wr_strobe_no(wr_n), .cycle_done_o(cyc_done),
    .burst_done_o(bur_done), .busy_o(busy), .fifo_en_o(fifo_en));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int f_act(logic [31:0] w, bit c);
    return c ? int'(w[17:13]) : int'(w[8:4]);
  endfunction
  function automatic int f_inact(logic [31:0] w, bit c);
    return c ? int'(w[12:9]) : int'(w[3:0]);
  endfunction
  function automatic int f_setup(logic [31:0] w, bit c);
    return c ? int'(w[27:25]) : int'(w[24:22]);
  endfunction

  task automatic step(bit noise);
    if (noise) begin
      start  = 1'($urandom);
      is_cmd = 1'($urandom);
      wr     = 1'($urandom);
      cnt    = CNT_W'($urandom);
      tim    = $urandom;
    end
    @(negedge clk);
  endtask

  task automatic run_burst(bit c, bit w, int n_req, logic [31:0] word, bit noise, string ctx);
    int n = (n_req == 0) ? 1 : n_req;
    int a = f_act(word, c), ia = f_inact(word, c), s = f_setup(word, c);
    string ptag = c ? "R3" : "R2";
    @(negedge clk);
    start = 1'b1; is_cmd = c; wr = w; cnt = CNT_W'(n_req); tim = word;
    @(negedge clk);
    start = 1'b0;
    chk({ctx, " R10 fifo"}, 32'(fifo_en), 32'(word[31]));
    for (int cy = 0; cy < n; cy++) begin
      int lead = (cy == 0 ? s : ia) + 1;
      for (int k = 0; k < lead; k++) begin
        chk({ctx, cy == 0 ? " R4 setup" : {" ", ptag, " inactive"}}, 32'({rd_n, wr_n}), 32'b11);
        chk({ctx, " R6 cycle_done"}, 32'(cyc_done), 0);
        chk({ctx, " R6 busy"}, 32'(busy), 1);
        step(noise);
      end
      for (int k = 0; k <= a; k++) begin
        chk({ctx, " ", ptag, "/R5 active"}, 32'({rd_n, wr_n}), w ? 32'b10 : 32'b01);
        chk({ctx, " R6 cycle_done"}, 32'(cyc_done), 32'(k == a));
        chk({ctx, " R7 burst_done"}, 32'(bur_done), 32'(k == a && cy == n - 1));
        step(noise);
      end
    end
    start = 1'b0;
    chk({ctx, " R6 busy_fall"}, 32'(busy), 0);
    chk({ctx, " R1 idle strobes"}, 32'({rd_n, wr_n, cyc_done, bur_done}), 32'b1100);
  endtask

  initial begin
    void'($urandom(32'h5eed_a7a0));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset strobes", 32'({rd_n, wr_n}), 32'b11);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset done", 32'({cyc_done, bur_done}), 0);
    chk("R10 reset fifo", 32'(fifo_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'({rd_n, wr_n, busy}), 32'b110);

    // directed corners
    run_burst(1'b0, 1'b1, 1, 32'h0000_0000, 1'b0, "min data write");
    run_burst(1'b1, 1'b0, 2, 32'h8FFF_FFFF, 1'b0, "max cmd read");
    run_burst(1'b0, 1'b0, 0, 32'h0140_0231, 1'b0, "R7 count zero");
    run_burst(1'b1, 1'b1, 3, 32'h0A00_A400, 1'b1, "R8 R9 noisy");
    run_burst(1'b0, 1'b1, 2, 32'h81C0_0015, 1'b1, "R8 R9 noisy data");

    // constrained random
    for (int i = 0; i < 40; i++) begin
      run_burst(1'($urandom), 1'($urandom), int'($urandom_range(0, 4)),
                $urandom, 1'($urandom), "random");
    end

    // R9: start is ignored while busy, busy must still drop after burst
    repeat (2) @(negedge clk);
    chk("R9 quiet idle", 32'(busy), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule